// File: doc/BRIEF.md
# Window Watchdog Timer

This peripheral watches software through a two-phase countdown. Once enabled it first runs a closed phase, timed from a programmable first count, and then an open phase, timed from a programmable second count. Software proves it is alive by restarting the timer during the open phase. A restart that comes too early, during the closed phase, is treated as a fault. So is a missed restart, where the open phase runs out. Either fault raises a reset request that lasts a fixed number of clock cycles. After that the timer falls back to the disabled state.

Software reaches the block through a simple word-addressed register port. The control/status register is guarded by an unlock bit. Software sets the unlock bit, and it is used up by the next accepted control/status write. The two count registers can only be changed while the timer is stopped. An interrupt flag marks the start of each open phase, so software knows it may kick the timer.

Top module: `win_watchdog`

## Requirements
- R1: After start, the closed phase lasts max(F,1) cycles and the open phase max(S,1) cycles, where F and S are the count registers at byte offsets 0x0C and 0x10. Status bit 8 (byte offset 0x04) reads 1 only during the open phase.
- R2: When the open phase ends with no restart, `rst_req` is high for exactly 4 consecutive cycles. The timer then returns to the disabled state, and status bit 0 reads 0.
- R3: An accepted status write with bit 8 = 1 and bit 0 = 1 during the open phase is a restart. It clears bit 8, starts a new closed phase of max(F,1) cycles, and raises no reset request.
- R4: An accepted status write with bit 8 = 1 during the closed phase raises `rst_req` in the cycle after that write.
- R5: A write to the status register takes effect only when unlock bit 0 at offset 0x00 is 1. The unlock bit reads back 0 after any accepted status write.
- R6: An accepted status write with bit 0 = 0 stops the timer during the open phase, and no reset request follows. The same write during the closed phase is ignored, and the phase runs on to its normal length.
- R7: Writes to offsets 0x0C and 0x10 are ignored while status bit 0 is 1. Read-back shows the old value, and the phase lengths are unchanged.
- R8: Status bit 16 and the `irq` output become 1 when an open phase begins. An accepted status write with bit 16 = 1 clears them.
- R9: After reset, `rst_req` and `irq` are 0, and the unlock, status and both count registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is zero when low |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Open-phase interrupt, follows status bit 16 |

## Verification
The bench sweeps every pair of first and second counts from 0 to 3. It measures both phase lengths and the length of the reset pulse. An off-by-one in the counter would stretch or shrink a phase by one cycle, and a design that did not treat zero as one cycle would hang or skip a phase. The bench kicks early, kicks on time and stops the timer inside each phase. A design that confused the phases would reset on a legal kick or accept an illegal one. It also repeats status writes with no fresh unlock, and writes the count registers while the timer runs. A design that kept the unlock bit would accept the second write. A design that let the counts change would show a changed read-back value or a shorter closed phase.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  // Byte offsets of the word registers
  localparam int unsigned OFF_UNLOCK = 'h00;
  localparam int unsigned OFF_STAT   = 'h04;
  localparam int unsigned OFF_FAULT  = 'h08;
  localparam int unsigned OFF_FIRST  = 'h0C;
  localparam int unsigned OFF_SECOND = 'h10;

  // Status register bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_OPEN = 8;
  localparam int unsigned BIT_IRQ  = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLOSED = 2'd1,
    ST_OPEN   = 2'd2,
    ST_TRIP   = 2'd3
  } wwd_state_e;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tmr_en,
  input  logic              tmr_open,
  input  logic              open_enter,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_kick,
  output logic              stat_acc,
  output logic              unlock,
  output logic              irq_flag,
  output logic [CNT_W-1:0]  first_cnt,
  output logic [CNT_W-1:0]  second_cnt
);
  logic              sel_unlock, sel_stat, sel_first, sel_second;
  logic              unlock_q, unlock_d, unlock_we;
  logic              flag_q, flag_d;
  logic [CNT_W-1:0]  first_q, second_q;
  logic              first_we, second_we;
  logic [DATA_W-1:0] rd_mux;

  // Address decode
  always_comb begin
    sel_unlock = (addr == ADDR_W'(OFF_UNLOCK));
    sel_stat   = (addr == ADDR_W'(OFF_STAT));
    sel_first  = (addr == ADDR_W'(OFF_FIRST));
    sel_second = (addr == ADDR_W'(OFF_SECOND));
  end

  // Protected status write and the commands it produces
  always_comb begin
    stat_acc  = wr_en && sel_stat && unlock_q;
    cmd_start = stat_acc && wdata[BIT_EN];
    cmd_stop  = stat_acc && !wdata[BIT_EN];
    cmd_kick  = stat_acc && wdata[BIT_OPEN];
  end

  // Unlock bit: set by software, consumed by an accepted status write
  always_comb begin
    unlock_we = (wr_en && sel_unlock) || stat_acc;
    unlock_d  = (wr_en && sel_unlock) ? wdata[0] : 1'b0;
  end

  // Interrupt flag: a new open phase wins over a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (open_enter)
      flag_d = 1'b1;
    else if (stat_acc && wdata[BIT_IRQ])
      flag_d = 1'b0;
  end

  // Count registers only move while stopped
  always_comb begin
    first_we  = wr_en && sel_first  && !tmr_en;
    second_we = wr_en && sel_second && !tmr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      flag_q   <= 1'b0;
      first_q  <= '0;
      second_q <= '0;
    end else begin
      if (unlock_we) unlock_q <= unlock_d;
      flag_q <= flag_d;
      if (first_we)  first_q  <= wdata[CNT_W-1:0];
      if (second_we) second_q <= wdata[CNT_W-1:0];
    end
  end

  // Read mux; the fault register reads as zero
  always_comb begin
    rd_mux = '0;
    if (sel_unlock) begin
      rd_mux[0] = unlock_q;
    end else if (sel_stat) begin
      rd_mux[BIT_EN]   = tmr_en;
      rd_mux[BIT_OPEN] = tmr_open;
      rd_mux[BIT_IRQ]  = flag_q;
    end else if (sel_first) begin
      rd_mux[CNT_W-1:0] = first_q;
    end else if (sel_second) begin
      rd_mux[CNT_W-1:0] = second_q;
    end
    rdata = rd_en ? rd_mux : '0;
  end

  assign unlock     = unlock_q;
  assign irq_flag   = flag_q;
  assign first_cnt  = first_q;
  assign second_cnt = second_q;
endmodule

// File: rtl/wwd_timer.sv
module wwd_timer
  import wwd_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_kick,
  input  logic [CNT_W-1:0] first_cnt,
  input  logic [CNT_W-1:0] second_cnt,
  output logic             tmr_en,
  output logic             tmr_open,
  output logic             open_enter,
  output logic             trip
);
  localparam int PLS_W = $clog2(RST_CYCLES + 1);
  localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(RST_CYCLES - 1);

  wwd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PLS_W-1:0] pls_q, pls_d;
  logic             phase_last;

  // A count of 0 or 1 ends the phase this cycle
  assign phase_last = (cnt_q[CNT_W-1:1] == '0);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    pls_d      = pls_q;
    open_enter = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_start) begin
          st_d  = ST_CLOSED;
          cnt_d = first_cnt;
        end
      end
      ST_CLOSED: begin
        if (cmd_kick) begin
          st_d  = ST_TRIP;
          pls_d = PLS_LOAD;
        end else if (phase_last) begin
          st_d       = ST_OPEN;
          cnt_d      = second_cnt;
          open_enter = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_OPEN: begin
        if (cmd_stop) begin
          st_d = ST_IDLE;
        end else if (cmd_kick) begin
          st_d  = ST_CLOSED;
          cnt_d = first_cnt;
        end else if (phase_last) begin
          st_d  = ST_TRIP;
          pls_d = PLS_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TRIP: begin
        if (pls_q == '0) st_d = ST_IDLE;
        else             pls_d = pls_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pls_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign tmr_en   = (st_q != ST_IDLE);
  assign tmr_open = (st_q == ST_OPEN);
  assign trip     = (st_q == ST_TRIP);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              irq
);
  logic             cmd_start, cmd_stop, cmd_kick, stat_acc, unlock_q;
  logic             tmr_en, tmr_open, open_enter, irq_flag;
  logic [CNT_W-1:0] first_cnt, second_cnt;

  wwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_en(tmr_en), .tmr_open(tmr_open),
    .open_enter(open_enter), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_kick(cmd_kick), .stat_acc(stat_acc), .unlock(unlock_q),
    .irq_flag(irq_flag), .first_cnt(first_cnt), .second_cnt(second_cnt)
  );

  wwd_timer #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_kick(cmd_kick), .first_cnt(first_cnt), .second_cnt(second_cnt),
    .tmr_en(tmr_en), .tmr_open(tmr_open), .open_enter(open_enter),
    .trip(rst_req)
  );

  assign irq = irq_flag;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int RST_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic rst_req,
  input logic irq,
  input logic tmr_en,
  input logic tmr_open,
  input logic stat_acc,
  input logic unlock_q
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (rst_req) run_q <= run_q + 8'd1;
    else              run_q <= '0;
  end

  // R2: the reset request never outlasts its fixed length
  p_pulse_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (run_q < 8'(RST_CYCLES)));

  // R2: the reset request always lasts its full length
  p_pulse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> ($past(run_q) == 8'(RST_CYCLES - 1)));

  // R2: after the pulse the timer is disabled
  p_idle_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> !tmr_en);

  // R1: no open phase while stopped
  p_open_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |-> !tmr_open);

  // R8: interrupt raised when an open phase starts
  p_irq_on_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_open) |-> irq);

  // R5: unlock consumed by an accepted status write
  p_unlock_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_acc |=> !unlock_q);
endmodule

bind win_watchdog wwd_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq),
  .tmr_en(tmr_en), .tmr_open(tmr_open), .stat_acc(stat_acc),
  .unlock_q(unlock_q)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rst_req;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;

  win_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    addr  = ADDR_W'(a);
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    addr  = ADDR_W'(a);
    rd_en = 1'b1;
    #1;
    v     = rdata;
    rd_en = 1'b0;
  endtask

  task automatic stat_wr(input logic [DATA_W-1:0] d);
    wr('h00, 32'd1);
    wr('h04, d);
  endtask

  task automatic wait_open(output int n);
    logic [DATA_W-1:0] v;
    n = 0;
    rd('h04, v);
    while (!v[8] && n < 200) begin
      @(negedge clk);
      n++;
      rd('h04, v);
    end
  endtask

  task automatic wait_trip(output int n);
    n = 0;
    while (!rst_req && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic trip_len(output int n);
    n = 0;
    while (rst_req && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic [DATA_W-1:0] v;
    int n;
    int hits;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check(rst_req == 1'b0, "R9", "rst_req", rst_req, 0);
    check(irq == 1'b0, "R9", "irq", irq, 0);
    rd('h00, v); check(v == 0, "R9", "unlock", v, 0);
    rd('h04, v); check(v == 0, "R9", "status", v, 0);
    rd('h0C, v); check(v == 0, "R9", "first count", v, 0);
    rd('h10, v); check(v == 0, "R9", "second count", v, 0);

    // R1/R2: sweep both counts over 0..3
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        wr('h0C, DATA_W'(f));
        wr('h10, DATA_W'(s));
        stat_wr(32'h1);
        wait_open(n);
        check(n == ((f < 1) ? 1 : f), "R1", "closed length", n, (f < 1) ? 1 : f);
        wait_trip(n);
        check(n == ((s < 1) ? 1 : s), "R1", "open length", n, (s < 1) ? 1 : s);
        trip_len(n);
        check(n == 4, "R2", "reset pulse length", n, 4);
        rd('h04, v);
        check(v[0] == 1'b0, "R2", "enable after pulse", v[0], 0);
      end
    end

    // R5: locked write ignored; unlock reads 0
    rd('h00, v); check(v[0] == 1'b0, "R5", "unlock consumed", v[0], 0);
    wr('h04, 32'h1);
    rd('h04, v); check(v[0] == 1'b0, "R5", "locked write ignored", v[0], 0);
    wr('h00, 32'h1);
    rd('h00, v); check(v[0] == 1'b1, "R5", "unlock set", v[0], 1);
    wr('h04, 32'h10000);
    wr('h04, 32'h1);
    rd('h04, v); check(v[0] == 1'b0, "R5", "second write needs unlock", v[0], 0);
    check(irq == 1'b0, "R8", "irq cleared by W1C", irq, 0);

    // R8/R3: interrupt and legal restart
    wr('h0C, 32'd2); wr('h10, 32'd5);
    stat_wr(32'h1);
    wait_open(n);
    check(irq == 1'b1, "R8", "irq at open start", irq, 1);
    stat_wr(32'h10101);
    rd('h04, v);
    check(v[8] == 1'b0, "R3", "closed after restart", v[8], 0);
    check(v[0] == 1'b1, "R3", "still enabled", v[0], 1);
    check(rst_req == 1'b0, "R3", "no reset on kick", rst_req, 0);
    check(irq == 1'b0, "R8", "irq cleared", irq, 0);
    wait_open(n);
    check(n == 2, "R3", "new closed length", n, 2);
    check(irq == 1'b1, "R8", "irq set again", irq, 1);

    // R6: stop inside open phase, no reset follows
    stat_wr(32'h10000);
    rd('h04, v);
    check(v[0] == 1'b0, "R6", "stopped in open", v[0], 0);
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      if (rst_req) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R6", "no reset after stop", hits, 0);

    // R4: early kick in closed phase
    wr('h0C, 32'd6); wr('h10, 32'd3);
    stat_wr(32'h1);
    stat_wr(32'h101);
    check(rst_req == 1'b1, "R4", "early kick trips", rst_req, 1);
    trip_len(n);
    check(n == 4, "R4", "early kick pulse length", n, 4);

    // R6: stop in closed phase ignored
    wr('h0C, 32'd8);
    stat_wr(32'h1);
    stat_wr(32'h0);
    rd('h04, v);
    check(v[0] == 1'b1, "R6", "stop ignored in closed", v[0], 1);
    wait_open(n);
    check(n == 6, "R6", "closed runs on", n, 6);
    stat_wr(32'h0);

    // R7: count writes while running ignored
    wr('h0C, 32'd5); wr('h10, 32'd8);
    stat_wr(32'h1);
    wr('h0C, 32'd1);
    rd('h0C, v);
    check(v == 5, "R7", "first count readback", v, 5);
    wait_open(n);
    check(n == 4, "R7", "closed length kept", n, 4);
    wr('h10, 32'd2);
    rd('h10, v);
    check(v == 8, "R7", "second count readback", v, 8);
    stat_wr(32'h101);
    wait_open(n);
    check(n == 5, "R7", "closed after restart kept", n, 5);
    stat_wr(32'h0);
    rd('h04, v);
    check(v[0] == 1'b0, "R6", "final stop", v[0], 0);

    finish_run();
  end
endmodule